// File: doc/BRIEF.md
# Serial Bus Byte Monitor

This block watches a three-wire open-collector peripheral bus (DATA, CLK and an attention line ATN) without ever driving it. All three lines are sampled by a fast system clock. The monitor follows the byte handshake from the talker-ready phase, through the listener-ready phase and an optional end-of-transfer marker, to eight data bits. For every byte that completes, it produces a one-cycle strobe together with the byte value and two flags. One flag says whether attention was asserted when the byte started, which marks a command byte. The other says whether the talker marked the byte as the last of a transfer.

A design places this block beside the bus pins to log or react to traffic, for example to trace commands or to spot the end of a file transfer. Each bus line passes through a two-flop synchronizer before use. Edges are found by comparing the newest synchronized sample with the one before it. A falling edge on ATN returns the handshake tracker to its start at any point.

Top module: `serial_byte_monitor`

## Requirements
- R1: While reset is asserted and after its release, byte_valid, byte_out, atn_flag and eoi_flag are all 0, and the tracker waits for a talker-ready condition.
- R2: A byte is accepted only after this sequence: DATA low while CLK is high (talker ready), then DATA high while CLK is high (listener ready), then CLK low, then eight CLK low-to-high-to-low cycles. byte_valid is then high for exactly one system clock.
- R3: Bits are captured on CLK rising edges. The first captured bit is byte_out[0] and the eighth is byte_out[7].
- R4: atn_flag reports the inverse of the ATN level at the moment the listener became ready. It is 1 when ATN was low at that moment.
- R5: eoi_flag is 1 when DATA went low while CLK was still high, after the listener became ready and before CLK first went low. The next byte without that marker reports eoi_flag 0.
- R6: If CLK goes low after talker ready and before listener ready, the transfer is abandoned. Later CLK pulses with DATA held high produce no byte.
- R7: A falling edge on ATN at any point abandons the byte in progress, and no byte is reported for it.
- R8: If the ATN falling edge reaches the tracker in the same cycle as the eighth CLK falling edge, no byte is reported.
- R9: byte_valid goes high on the second system clock edge after the edge that first samples the eighth CLK low level.
- R10: byte_out, atn_flag and eoi_flag change only in a cycle where byte_valid is high, and otherwise hold the values of the last byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_data | input | 1 | DATA line level |
| bus_clk | input | 1 | CLK line level |
| bus_atn | input | 1 | ATN line level (low means attention) |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_out | output | DATA_BITS | Received byte, first bit in bit 0 |
| atn_flag | output | 1 | Byte was sent under attention |
| eoi_flag | output | 1 | Byte was marked as the last of a transfer |

## Verification
The bench aims at the points where a plain shift receiver would go wrong. A tracker that ignores the abort path would lock onto stray CLK pulses and report a phantom byte. One that does not reset on ATN would finish a cut-off byte with garbage bits. One that gives the eighth CLK edge priority over a coincident ATN fall would report a byte that should be dropped. Bit order is checked with asymmetric patterns, so a reversed shift shows a different value. A byte with the end marker is followed by one without it, to catch a flag that is never cleared. A behavioural model checks output timing on every clock, which catches an extra or missing pipeline stage.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TALK   = 2'd1,
    ST_LISTEN = 2'd2,
    ST_BITS   = 2'd3
  } sbm_step_e;

  typedef struct packed {
    logic atn;
    logic clk;
    logic data;
  } sbm_lines_t;

  localparam int unsigned LINE_COUNT = 3;

endpackage

// File: rtl/sbm_rst_sync.sv
module sbm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sbm_line_sync.sv
module sbm_line_sync #(
  parameter int unsigned WIDTH     = 3,
  parameter int unsigned STAGES    = 2,
  parameter logic [WIDTH-1:0] IDLE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] prev
);

  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [DEPTH-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= {DEPTH{IDLE[g]}};
      else        sh_q <= {sh_q[DEPTH-2:0], din[g]};
    end

    assign level[g] = sh_q[STAGES-1];
    assign prev[g]  = sh_q[STAGES];
  end

endmodule

// File: rtl/sbm_seq.sv
module sbm_seq
  import sbm_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  sbm_lines_t           level,
  input  sbm_lines_t           prev,
  output logic                 byte_valid,
  output logic [DATA_BITS-1:0] byte_out,
  output logic                 atn_flag,
  output logic                 eoi_flag,
  output sbm_step_e            step,
  output logic                 atn_fall
);

  localparam int unsigned CW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(DATA_BITS - 1);

  sbm_step_e            step_q, step_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [DATA_BITS-1:0] sh_q, sh_d;
  logic                 atnw_q, atnw_d;
  logic                 eoiw_q, eoiw_d;
  logic                 valid_q;
  logic [DATA_BITS-1:0] byte_q;
  logic                 atn_q, eoi_q;
  logic                 emit;
  logic                 clk_rise, clk_fall;

  assign atn_fall = prev.atn & ~level.atn;
  assign clk_rise = ~prev.clk & level.clk;
  assign clk_fall = prev.clk & ~level.clk;

  always_comb begin
    step_d = step_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    atnw_d = atnw_q;
    eoiw_d = eoiw_q;
    emit   = 1'b0;
    if (atn_fall) begin
      step_d = ST_IDLE;
    end else begin
      unique case (step_q)
        ST_IDLE: begin
          if (!level.data && level.clk) step_d = ST_TALK;
        end
        ST_TALK: begin
          if (level.data && level.clk) begin
            atnw_d = ~level.atn;
            eoiw_d = 1'b0;
            cnt_d  = '0;
            sh_d   = '0;
            step_d = ST_LISTEN;
          end else if (!level.clk) begin
            step_d = ST_IDLE;
          end
        end
        ST_LISTEN: begin
          if (!level.data && level.clk) eoiw_d = 1'b1;
          else if (!level.clk)          step_d = ST_BITS;
        end
        ST_BITS: begin
          if (clk_rise) sh_d[cnt_q] = level.data;
          if (clk_fall) begin
            if (cnt_q == LAST_BIT) begin
              emit   = 1'b1;
              cnt_d  = '0;
              step_d = ST_IDLE;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: step_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      atnw_q  <= 1'b0;
      eoiw_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      step_q  <= step_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      atnw_q  <= atnw_d;
      eoiw_q  <= eoiw_d;
      valid_q <= emit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      atn_q  <= 1'b0;
      eoi_q  <= 1'b0;
    end else if (emit) begin
      byte_q <= sh_q;
      atn_q  <= atnw_q;
      eoi_q  <= eoiw_q;
    end
  end

  assign byte_valid = valid_q;
  assign byte_out   = byte_q;
  assign atn_flag   = atn_q;
  assign eoi_flag   = eoi_q;
  assign step       = step_q;

endmodule

// File: rtl/serial_byte_monitor.sv
module serial_byte_monitor
  import sbm_pkg::*;
#(
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_data,
  input  logic                 bus_clk,
  input  logic                 bus_atn,
  output logic                 byte_valid,
  output logic [DATA_BITS-1:0] byte_out,
  output logic                 atn_flag,
  output logic                 eoi_flag
);

  logic       rst_n_sync;
  sbm_lines_t raw_lines;
  sbm_lines_t lvl_lines;
  sbm_lines_t prv_lines;
  sbm_step_e  step;
  logic       atn_fall;

  assign raw_lines = '{atn: bus_atn, clk: bus_clk, data: bus_data};

  sbm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  sbm_line_sync #(
    .WIDTH  (LINE_COUNT),
    .STAGES (SYNC_STAGES),
    .IDLE   ('1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .din   (raw_lines),
    .level (lvl_lines),
    .prev  (prv_lines)
  );

  sbm_seq #(.DATA_BITS(DATA_BITS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .level      (lvl_lines),
    .prev       (prv_lines),
    .byte_valid (byte_valid),
    .byte_out   (byte_out),
    .atn_flag   (atn_flag),
    .eoi_flag   (eoi_flag),
    .step       (step),
    .atn_fall   (atn_fall)
  );

endmodule

// File: rtl/sbm_checker.sv
module sbm_checker
  import sbm_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input sbm_step_e            step,
  input logic                 atn_fall,
  input logic                 byte_valid,
  input logic [DATA_BITS-1:0] byte_out,
  input logic                 atn_flag,
  input logic                 eoi_flag
);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid); // R2

  AST_VALID_AFTER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> ($past(step) == ST_BITS) && (step == ST_IDLE)); // R2

  AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |-> $stable({byte_out, atn_flag, eoi_flag})); // R10

  AST_ATN_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    atn_fall |=> (step == ST_IDLE)); // R7

  AST_ATN_BLOCKS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    atn_fall |=> !byte_valid); // R8

endmodule

bind serial_byte_monitor sbm_checker #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .step       (step),
  .atn_fall   (atn_fall),
  .byte_valid (byte_valid),
  .byte_out   (byte_out),
  .atn_flag   (atn_flag),
  .eoi_flag   (eoi_flag)
);

// File: tb/test_serial_byte_monitor.sv
module test_serial_byte_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_data = 1'b1;
  logic       bus_clk = 1'b1;
  logic       bus_atn = 1'b1;
  logic       byte_valid;
  logic [7:0] byte_out;
  logic       atn_flag;
  logic       eoi_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_byte_monitor i_serial_byte_monitor (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_clk(bus_clk),
    .bus_atn(bus_atn), .byte_valid(byte_valid), .byte_out(byte_out),
    .atn_flag(atn_flag), .eoi_flag(eoi_flag)
  );

  // Behavioural reference: history of sampled lines {atn,clk,data}
  logic [2:0] hist[$];
  int         m_step, m_cnt;
  logic [7:0] m_sh;
  logic       m_atn, m_eoi;
  logic       e_valid, e_atn, e_eoi;
  logic [7:0] e_byte;
  logic [9:0] got[$];

  initial begin
    hist = '{3'b111, 3'b111, 3'b111};
    m_step = 0; m_cnt = 0; m_sh = 0; m_atn = 0; m_eoi = 0;
    e_valid = 0; e_byte = 0; e_atn = 0; e_eoi = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{3'b111, 3'b111, 3'b111};
      m_step = 0; m_cnt = 0; m_sh = 0; m_atn = 0; m_eoi = 0;
      e_valid = 0; e_byte = 0; e_atn = 0; e_eoi = 0;
    end else begin
      logic [2:0] lv, pv;
      lv = hist[1];
      pv = hist[0];
      e_valid = 0;
      if (pv[2] && !lv[2]) begin
        m_step = 0;
      end else if (m_step == 0) begin
        if (!lv[0] && lv[1]) m_step = 1;
      end else if (m_step == 1) begin
        if (lv[0] && lv[1]) begin
          m_atn = !lv[2]; m_eoi = 0; m_cnt = 0; m_sh = 0; m_step = 2;
        end else if (!lv[1]) m_step = 0;
      end else if (m_step == 2) begin
        if (!lv[0] && lv[1]) m_eoi = 1;
        else if (!lv[1]) m_step = 3;
      end else begin
        if (!pv[1] && lv[1]) m_sh[m_cnt] = lv[0];
        if (pv[1] && !lv[1]) begin
          m_cnt++;
          if (m_cnt == 8) begin
            e_valid = 1; e_byte = m_sh; e_atn = m_atn; e_eoi = m_eoi;
            m_cnt = 0; m_step = 0;
          end
        end
      end
      hist.push_back({bus_atn, bus_clk, bus_data});
      void'(hist.pop_front());
    end
  end

  // R9 / R10: compare against the model on every clock, and log bytes
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if ({byte_valid, byte_out, atn_flag, eoi_flag} !== {e_valid, e_byte, e_atn, e_eoi}) begin
        errors++;
        $display("FAIL R9 cycle model: got v=%0b b=%h a=%0b e=%0b expected v=%0b b=%h a=%0b e=%0b",
                 byte_valid, byte_out, atn_flag, eoi_flag, e_valid, e_byte, e_atn, e_eoi);
      end
      if (byte_valid) got.push_back({atn_flag, eoi_flag, byte_out});
    end
  end

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_byte(string tag, logic a, logic e, logic [7:0] b);
    checks++;
    if (got.size() == 0) begin
      errors++;
      $display("FAIL %s: got no byte, expected byte=%h atn=%0b eoi=%0b", tag, b, a, e);
    end else begin
      logic [9:0] g;
      g = got.pop_front();
      if (g !== {a, e, b}) begin
        errors++;
        $display("FAIL %s: got byte=%h atn=%0b eoi=%0b, expected byte=%h atn=%0b eoi=%0b",
                 tag, g[7:0], g[9], g[8], b, a, e);
      end
    end
  endtask

  task automatic expect_none(string tag);
    checks++;
    if (got.size() != 0) begin
      errors++;
      $display("FAIL %s: got %0d bytes, expected 0", tag, got.size());
      got.delete();
    end
  endtask

  task automatic handshake(bit eoi);
    bus_data = 1'b0; hold(HOLD);
    bus_clk  = 1'b1; hold(HOLD);   // talker ready
    bus_data = 1'b1; hold(HOLD);   // listener ready
    if (eoi) begin
      bus_data = 1'b0; hold(HOLD);
      bus_data = 1'b1; hold(HOLD);
    end
    bus_clk = 1'b0; hold(HOLD);
  endtask

  task automatic send_bits(logic [7:0] b, int nbits);
    for (int i = 0; i < nbits; i++) begin
      bus_data = b[i]; hold(HOLD);
      bus_clk  = 1'b1; hold(HOLD);
      bus_clk  = 1'b0; hold(HOLD);
    end
  endtask

  task automatic send_byte(logic [7:0] b, bit eoi);
    handshake(eoi);
    send_bits(b, 8);
    hold(6);
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finished = 1;
    report();
    $finish;
  end

  initial begin
    hold(3);
    // R1: outputs cleared while reset is held
    checks++;
    if ({byte_valid, byte_out, atn_flag, eoi_flag} !== 11'd0) begin
      errors++;
      $display("FAIL R1 reset: got %b expected 0", {byte_valid, byte_out, atn_flag, eoi_flag});
    end
    rst_n = 1'b1;
    hold(8);
    checks++;
    if ({byte_valid, byte_out, atn_flag, eoi_flag} !== 11'd0) begin
      errors++;
      $display("FAIL R1 after release: got %b expected 0", {byte_valid, byte_out, atn_flag, eoi_flag});
    end
    bus_clk = 1'b0; hold(HOLD);

    // R2 R3: plain data byte, asymmetric pattern checks bit order
    send_byte(8'hA6, 0);
    expect_byte("R3 data byte A6", 1'b0, 1'b0, 8'hA6);
    send_byte(8'h01, 0);
    expect_byte("R2 data byte 01", 1'b0, 1'b0, 8'h01);

    // R4: command byte under attention
    bus_atn = 1'b0; hold(HOLD);
    send_byte(8'h28, 0);
    expect_byte("R4 command byte", 1'b1, 1'b0, 8'h28);
    bus_atn = 1'b1; hold(HOLD);

    // R5: end marker, then cleared on next byte
    send_byte(8'h3C, 1);
    expect_byte("R5 eoi set", 1'b0, 1'b1, 8'h3C);
    send_byte(8'h80, 0);
    expect_byte("R5 eoi cleared", 1'b0, 1'b0, 8'h80);

    // R6: abort between talker ready and listener ready
    bus_data = 1'b0; hold(HOLD);
    bus_clk  = 1'b1; hold(HOLD);
    bus_clk  = 1'b0; hold(HOLD);
    bus_data = 1'b1; hold(HOLD);
    for (int i = 0; i < 8; i++) begin
      bus_clk = 1'b1; hold(HOLD);
      bus_clk = 1'b0; hold(HOLD);
    end
    hold(6);
    expect_none("R6 aborted transfer");
    send_byte(8'h5A, 0);
    expect_byte("R6 recovery byte", 1'b0, 1'b0, 8'h5A);

    // R7: ATN falls in the middle of the bits
    handshake(0);
    send_bits(8'hFF, 4);
    bus_data = 1'b1;
    bus_atn  = 1'b0; hold(HOLD);
    for (int i = 0; i < 4; i++) begin
      bus_clk = 1'b1; hold(HOLD);
      bus_clk = 1'b0; hold(HOLD);
    end
    hold(6);
    expect_none("R7 ATN cut byte");
    bus_atn = 1'b1; hold(HOLD);
    send_byte(8'hC3, 0);
    expect_byte("R7 recovery byte", 1'b0, 1'b0, 8'hC3);

    // R8: ATN fall coincides with the eighth CLK fall
    handshake(0);
    send_bits(8'h77, 7);
    bus_data = 1'b0; hold(HOLD);
    bus_clk  = 1'b1; hold(HOLD);
    bus_clk  = 1'b0;
    bus_atn  = 1'b0; hold(HOLD);
    hold(6);
    expect_none("R8 coincident ATN fall");
    bus_data = 1'b1;
    bus_atn  = 1'b1; hold(HOLD);

    // R10: outputs still show the last reported byte
    checks++;
    if ({byte_out, atn_flag, eoi_flag} !== {8'hC3, 1'b0, 1'b0}) begin
      errors++;
      $display("FAIL R10 hold: got byte=%h a=%0b e=%0b expected byte=c3 a=0 e=0",
               byte_out, atn_flag, eoi_flag);
    end

    // R9 timing is covered by the per-cycle model; one final byte with both flags
    bus_atn = 1'b0; hold(HOLD);
    send_byte(8'h96, 1);
    expect_byte("R9 command with eoi", 1'b1, 1'b1, 8'h96);
    bus_atn = 1'b1; hold(HOLD);

    finished = 1;
    report();
    $finish;
  end

endmodule